// File: doc/BRIEF.md
# Input Magnitude Window Monitor

This block watches a stream of sample magnitudes and condenses each observation window into one statistic. There are three statistics: the largest magnitude seen, a saturating sum of magnitudes from which software can later form a mean, and a count of samples above a programmable threshold. A down-counting window timer is loaded from a period register. When the timer ends a window, the running statistic moves into a holding register, a fresh window begins and an interrupt request pulses.

Software can take the window boundary away from the timer. In that case the timer still runs and still raises interrupts, but the hand-over into the holding register happens only when the host reads that register. That read also restarts the timer. An optional clear-on-read restarts the statistic at the same time. The value it restarts from depends on the statistic being gathered. The block has a single-cycle register port, and read data returns one cycle after the read strobe.

Top module: `mag_monitor`

## Requirements
- R1: After reset, `irq` is 0, every readable register returns 0, and no window is running.
- R2: The registers are laid out as follows. Address 0 is control: bit0 run, bits[2:1] statistic select (00 peak, 01 sum, 1x threshold count), bit3 host-driven transfer, bit4 clear-on-read, bit5 interrupt enable. Address 1 is the 24-bit period. Address 2 is the 10-bit threshold. Address 3 gives holding bits[31:0] and address 4 gives holding bits above 31. A read strobe returns its data in the following cycle. A control write with run=1 starts a window: the timer loads the period and the statistic clears to 0.
- R3: The timer decrements once per clock while running. A window ends in the cycle in which the count is 1, and the timer then reloads, so windows end every `period` cycles. The first window ends `period` clock edges after the starting write.
- R4: In peak mode the statistic holds the largest magnitude among valid samples.
- R5: In sum mode the statistic adds each valid magnitude and saturates at its all-ones maximum.
- R6: In threshold mode the statistic counts valid samples whose magnitude is strictly greater than the threshold. The count saturates at its maximum.
- R7: With host-driven transfer off, a window end copies the statistic into the holding register. The statistic then restarts: at 0 in threshold mode, and in peak and sum modes at the magnitude of the sample present in that cycle (0 if that sample is not valid).
- R8: Each window end produces a one-cycle `irq` pulse when interrupts are enabled, and no pulse when they are disabled.
- R9: With host-driven transfer on, a window end still pulses `irq` but leaves the holding register and the statistic unchanged. A read of address 3 returns the current statistic, copies it into the holding register and reloads the timer.
- R10: Clear-on-read acts only with host-driven transfer on. The transferring read then restarts the statistic as in R7. With host-driven transfer off, the bit has no effect.
- R11: With clear-on-read off, a transferring read leaves the statistic to keep accumulating from its previous value.
- R12: When a transferring read falls in the same cycle as a window end, the read wins: the timer reloads once and no interrupt is raised for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample magnitude is valid this cycle |
| smp_mag | input | MAG_W (10) | Sample magnitude |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | One-cycle window-end interrupt request |

## Verification
Several properties are checked on every clock. The timer's load and decrement steps are checked, and a peak never falls below the sample just taken. A sum or count never drops between restarts, and a sample at or below the threshold leaves the count alone. Each transfer lands the prior statistic in the holding register, and the holding register stays untouched in host-driven mode unless a read transfers into it. Interrupts stay silent while disabled, while stopped, and on a read/window-end collision. The exact window lengths, the restart value in each mode, the timer reload caused by a read, and saturation of the narrow counter show up only in the bench's directed scenarios, which compare read data and interrupt timing against hand-derived values.

// File: rtl/mag_monitor_pkg.sv
// Shared types for the magnitude window monitor.
// Assumes: control register layout is fixed by the struct below (bit0 first).
package mag_monitor_pkg;

    typedef enum logic [1:0] {
        STAT_PEAK  = 2'd0,
        STAT_SUM   = 2'd1,
        STAT_COUNT = 2'd2
    } stat_mode_e;

    // Packed control word; last field is bit 0.
    typedef struct packed {
        logic       irq_en;     // bit5
        logic       clr_rd;     // bit4
        logic       host_xfer;  // bit3
        logic [1:0] fsel;       // bits[2:1]
        logic       run;        // bit0
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_PERIOD  = 3'd1;
    localparam logic [2:0] A_THRESH  = 3'd2;
    localparam logic [2:0] A_HOLD_LO = 3'd3;
    localparam logic [2:0] A_HOLD_HI = 3'd4;

    // Statistic select: upper bit set means threshold count regardless of lower bit.
    function automatic stat_mode_e decode_mode(input logic [1:0] fsel);
        if (fsel[1])      return STAT_COUNT;
        else if (fsel[0]) return STAT_SUM;
        else              return STAT_PEAK;
    endfunction

endpackage

// File: rtl/mag_window_timer.sv
// Window timer: down counter loaded from the period value.
// Signals expiry while the count is 1 (or 0, so a zero period acts as 1),
// and reloads itself on expiry. An explicit load overrides everything.
// Assumes: synchronous active-low reset; run gates counting only.
module mag_window_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count is at its final step of the window.
    assign expire_o = run_i && (cnt_q <= CNT_W'(1));

    // Load, reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= period_i;
        else if (run_i) begin
            if (cnt_q <= CNT_W'(1)) cnt_q <= period_i;
            else                    cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R3
    load_takes_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(period_i)));

    // R3
    count_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/mag_stat_engine.sv
// Working statistic: peak, saturating sum, or saturating threshold count.
// zero_i forces 0 (window start); clr_i loads the mode's restart value.
// Assumes: STAT_W >= MAG_W; zero_i has priority over clr_i.
module mag_stat_engine
    import mag_monitor_pkg::*;
#(
    parameter int unsigned MAG_W  = 10,
    parameter int unsigned STAT_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  stat_mode_e        mode_i,
    input  logic [MAG_W-1:0]  thr_i,
    input  logic              smp_valid_i,
    input  logic [MAG_W-1:0]  smp_mag_i,
    input  logic              zero_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] work_o
);

    localparam logic [STAT_W-1:0] STAT_MAX = {STAT_W{1'b1}};

    logic [STAT_W-1:0] work_q;
    logic [STAT_W-1:0] mag_ext;
    logic [STAT_W:0]   sum_wide;
    logic [STAT_W-1:0] fresh;
    logic [STAT_W-1:0] upd;

    assign mag_ext  = STAT_W'(smp_mag_i);
    assign sum_wide = {1'b0, work_q} + {1'b0, mag_ext};

    // Restart value: current sample for peak and sum, zero for count.
    always_comb begin
        if (mode_i == STAT_COUNT || !smp_valid_i) fresh = '0;
        else                                      fresh = mag_ext;
    end

    // Per-sample update for the selected statistic.
    always_comb begin
        upd = work_q;
        if (smp_valid_i) begin
            unique case (mode_i)
                STAT_PEAK:  if (mag_ext > work_q) upd = mag_ext;
                STAT_SUM:   upd = sum_wide[STAT_W] ? STAT_MAX : sum_wide[STAT_W-1:0];
                STAT_COUNT: if (smp_mag_i > thr_i && work_q != STAT_MAX) upd = work_q + STAT_W'(1);
                default:    upd = work_q;
            endcase
        end
    end

    // Statistic register.
    always_ff @(posedge clk) begin
        if (!rst_n)      work_q <= '0;
        else if (zero_i) work_q <= '0;
        else if (clr_i)  work_q <= fresh;
        else if (en_i)   work_q <= upd;
    end

    assign work_o = work_q;

    // R4
    peak_covers_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !zero_i && !clr_i && smp_valid_i && mode_i == STAT_PEAK)
        |=> (work_q >= STAT_W'($past(smp_mag_i))));

    // R5
    sum_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !zero_i && !clr_i && mode_i == STAT_SUM) |=> (work_q >= $past(work_q)));

    // R6
    count_never_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !zero_i && !clr_i && mode_i == STAT_COUNT) |=> (work_q >= $past(work_q)));

    // R6
    below_thr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !zero_i && !clr_i && mode_i == STAT_COUNT && smp_valid_i && smp_mag_i <= thr_i)
        |=> $stable(work_q));

endmodule

// File: rtl/mag_monitor.sv
// Magnitude window monitor top: registers, transfer/clear control, interrupt.
// Window end comes from the timer, or, in host-driven mode, from a read of
// the low holding word. Host read wins over a same-cycle window end.
// Assumes: MAG_W <= DATA_W, PER_W <= DATA_W, MAG_W <= STAT_W <= 2*DATA_W.
module mag_monitor
    import mag_monitor_pkg::*;
#(
    parameter int unsigned MAG_W  = 10,
    parameter int unsigned STAT_W = 34,
    parameter int unsigned PER_W  = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [MAG_W-1:0]  smp_mag,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int unsigned WIDE_W = 2 * DATA_W;

    ctrl_t             ctrl_q;
    logic [PER_W-1:0]  period_q;
    logic [MAG_W-1:0]  thr_q;
    logic [STAT_W-1:0] hold_q;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    logic [STAT_W-1:0] work_w;
    logic              expire_w;
    logic              start_w;
    logic              rd_hold_w;
    logic              host_xfer_w;
    logic              win_end_w;
    logic              auto_xfer_w;
    logic              xfer_w;
    logic              clr_w;
    logic [WIDE_W-1:0] hold_wide;
    logic [WIDE_W-1:0] work_wide;
    logic [DATA_W-1:0] rd_src;
    stat_mode_e        mode_w;

    assign mode_w      = decode_mode(ctrl_q.fsel);
    assign start_w     = reg_wr && (reg_addr == ADDR_W'(A_CTRL)) && reg_wdata[0];
    assign rd_hold_w   = reg_rd && (reg_addr == ADDR_W'(A_HOLD_LO));
    assign host_xfer_w = ctrl_q.run && ctrl_q.host_xfer && rd_hold_w && !start_w;
    assign win_end_w   = expire_w && !host_xfer_w && !start_w;
    assign auto_xfer_w = win_end_w && !ctrl_q.host_xfer;
    assign xfer_w      = host_xfer_w || auto_xfer_w;
    assign clr_w       = auto_xfer_w || (host_xfer_w && ctrl_q.clr_rd);

    mag_window_timer #(.CNT_W(PER_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q.run),
        .load_i   (start_w || host_xfer_w),
        .period_i (period_q),
        .expire_o (expire_w)
    );

    mag_stat_engine #(.MAG_W(MAG_W), .STAT_W(STAT_W)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl_q.run),
        .mode_i      (mode_w),
        .thr_i       (thr_q),
        .smp_valid_i (smp_valid),
        .smp_mag_i   (smp_mag),
        .zero_i      (start_w),
        .clr_i       (clr_w),
        .work_o      (work_w)
    );

    // Zero-extend statistic and holding value to two data words.
    always_comb begin
        hold_wide = '0;
        work_wide = '0;
        hold_wide[STAT_W-1:0] = hold_q;
        work_wide[STAT_W-1:0] = work_w;
    end

    // Read-data source selection by address.
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(A_CTRL):    rd_src = DATA_W'(ctrl_q);
            ADDR_W'(A_PERIOD):  rd_src = DATA_W'(period_q);
            ADDR_W'(A_THRESH):  rd_src = DATA_W'(thr_q);
            ADDR_W'(A_HOLD_LO): rd_src = host_xfer_w ? work_wide[DATA_W-1:0] : hold_wide[DATA_W-1:0];
            ADDR_W'(A_HOLD_HI): rd_src = hold_wide[WIDE_W-1:DATA_W];
            default:            rd_src = '0;
        endcase
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            thr_q    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CTRL))   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_addr == ADDR_W'(A_PERIOD)) period_q <= reg_wdata[PER_W-1:0];
            if (reg_addr == ADDR_W'(A_THRESH)) thr_q    <= reg_wdata[MAG_W-1:0];
        end
    end

    // Holding register captures the statistic on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (xfer_w) hold_q <= work_w;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_src;
    end

    // One-cycle interrupt pulse per window end.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= win_end_w && ctrl_q.irq_en;
    end

    assign reg_rdata = rdata_q;
    assign irq       = irq_q;

    // R7
    xfer_lands_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_w |=> (hold_q == $past(work_w)));

    // R9
    host_mode_hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.host_xfer && !rd_hold_w) |=> $stable(hold_q));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.irq_en |=> !irq);

    // R1
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> !irq);

    // R12
    collision_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_w && host_xfer_w) |=> !irq);

endmodule

// File: tb/mag_monitor_tb_top.sv
// Directed bench: one task per scenario. A second instance with a narrow
// statistic shares all inputs and shows saturation.
module mag_monitor_tb_top;

    localparam int CLK_P = 10;
    localparam int NARROW_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_mag = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_m;
    logic [31:0] rdata_s;
    logic        irq_m;
    logic        irq_s;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    mag_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mag(smp_mag),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_m), .irq(irq_m)
    );

    mag_monitor #(.STAT_W(NARROW_W)) narrow_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mag(smp_mag),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_s), .irq(irq_s)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [9:0] m);
        smp_valid = v;
        smp_mag   = m;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        smp_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic v, input logic [9:0] m,
                      output logic [31:0] om, output logic [31:0] os);
        smp_valid = v; smp_mag = m;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0; smp_valid = 1'b0;
        om = rdata_m; os = rdata_s;
    endtask

    task automatic setup(input int per, input int thr, input logic [31:0] ctrl);
        wr(3'd1, per);
        wr(3'd2, thr);
        wr(3'd0, ctrl);
    endtask

    task automatic t_reset();
        logic [31:0] m, s;
        chk("R1 irq after reset", irq_m, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R1 holding after reset", m, 0);
        rd(3'd0, 0, 0, m, s);
        chk("R1 control after reset", m, 0);
    endtask

    task automatic t_count();
        logic [31:0] m, s;
        setup(8, 100, 32'h25);
        drive(1, 50); drive(1, 101); drive(1, 100); drive(1, 200);
        drive(1, 1023); drive(0, 999); drive(1, 150);
        chk("R3 no irq before window end", irq_m, 0);
        drive(1, 500);
        chk("R8 irq at window end", irq_m, 1);
        rd(3'd3, 0, 0, m, s);
        chk("R6 count above threshold", m, 4);
        chk("R8 irq single cycle", irq_m, 0);
        for (int i = 0; i < 6; i++) drive(0, 0);
        chk("R3 no irq mid second window", irq_m, 0);
        drive(0, 0);
        chk("R3 periodic window end", irq_m, 1);
        rd(3'd3, 0, 0, m, s);
        chk("R7 count restarts at zero", m, 0);
        rd(3'd0, 0, 0, m, s);
        chk("R2 control readback", m, 32'h25);
        wr(3'd0, 0);
        for (int i = 0; i < 10; i++) drive(0, 0);
        chk("R1 no irq when stopped", irq_m, 0);
    endtask

    task automatic t_peak();
        logic [31:0] m, s;
        setup(6, 0, 32'h21);
        drive(1, 30); drive(1, 700); drive(1, 5); drive(1, 699); drive(1, 0);
        drive(1, 321);
        chk("R8 irq peak window", irq_m, 1);
        rd(3'd3, 0, 0, m, s);
        chk("R4 peak value", m, 700);
        for (int i = 0; i < 4; i++) drive(0, 0);
        chk("R3 no early end", irq_m, 0);
        drive(0, 0);
        chk("R3 second peak window end", irq_m, 1);
        rd(3'd3, 0, 0, m, s);
        chk("R7 peak restarts from sample", m, 321);
        wr(3'd0, 0);
    endtask

    task automatic t_sum();
        logic [31:0] m, s;
        setup(5, 0, 32'h03);
        drive(1, 1000); drive(1, 1000); drive(1, 23); drive(1, 1);
        drive(1, 7);
        chk("R8 irq disabled", irq_m, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R5 sum value", m, 2024);
        chk("R5 narrow sum unsaturated", s, 2024);
        rd(3'd4, 0, 0, m, s);
        chk("R2 high holding word", m, 0);
        setup(10, 0, 32'h03);
        for (int i = 0; i < 9; i++) drive(1, 1023);
        drive(0, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R5 wide sum", m, 9207);
        chk("R5 narrow sum saturates", s, 4095);
        wr(3'd0, 0);
    endtask

    task automatic t_count_sat();
        logic [31:0] m, s;
        setup(4300, 0, 32'h05);
        for (int i = 0; i < 4299; i++) drive(1, 5);
        drive(0, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R6 wide count", m, 4299);
        chk("R6 narrow count saturates", s, 4095);
        wr(3'd0, 0);
    endtask

    task automatic t_host();
        logic [31:0] m, s;
        setup(4, 0, 32'h2B);
        drive(1, 10); drive(1, 20); drive(1, 30); drive(1, 40);
        chk("R9 irq still raised", irq_m, 1);
        drive(1, 5);
        rd(3'd3, 0, 0, m, s);
        chk("R9 read returns uncleared statistic", m, 105);
        drive(1, 1);
        rd(3'd3, 0, 0, m, s);
        chk("R11 accumulation continues", m, 106);
        chk("R9 no irq after read", irq_m, 0);
        drive(0, 0); drive(0, 0); drive(0, 0);
        chk("R9 read reloaded timer", irq_m, 0);
        drive(0, 0);
        chk("R9 window end after reload", irq_m, 1);
        wr(3'd0, 0);
    endtask

    task automatic t_clear_on_read();
        logic [31:0] m, s;
        setup(100, 0, 32'h19);
        drive(1, 400); drive(1, 90);
        rd(3'd3, 1, 77, m, s);
        chk("R10 peak read value", m, 400);
        drive(1, 50);
        rd(3'd3, 0, 0, m, s);
        chk("R10 peak restarts from read-cycle sample", m, 77);
        setup(100, 100, 32'h1D);
        drive(1, 200); drive(1, 300);
        rd(3'd3, 1, 500, m, s);
        chk("R10 count read value", m, 2);
        drive(0, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R10 count restarts at zero", m, 0);
        setup(6, 100, 32'h15);
        drive(1, 200); drive(1, 200); drive(1, 200);
        rd(3'd3, 0, 0, m, s);
        drive(1, 200);
        drive(0, 0);
        rd(3'd3, 0, 0, m, s);
        chk("R10 clear-on-read ignored without host mode", m, 4);
        wr(3'd0, 0);
    endtask

    task automatic t_collide();
        logic [31:0] m, s;
        setup(3, 10, 32'h2D);
        drive(1, 50); drive(1, 60);
        rd(3'd3, 0, 0, m, s);
        chk("R12 read value on collision", m, 2);
        chk("R12 no irq on collision", irq_m, 0);
        drive(0, 0); drive(0, 0);
        chk("R12 single reload", irq_m, 0);
        drive(0, 0);
        chk("R12 next window end", irq_m, 1);
        wr(3'd0, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_peak();
        t_sum();
        t_count_sat();
        t_host();
        t_clear_on_read();
        t_collide();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule